// File: doc/BRIEF.md
# Integer Minimum/Maximum Selector with Condition Field

This combinational unit picks the smaller or the larger of two 64-bit integer operands. A 3-bit mode chooses unsigned or signed ordering, a full doubleword or a low-word comparison, and minimum or maximum. A separate input replaces the first operand with the constant zero, as an execution unit does when the first register field names register zero.

The unit has a single unsigned magnitude comparator. Each operand is first prepared. In word mode its low 32 bits move into the upper half and zeros fill the lower half. In signed mode the top bit of the prepared value is inverted. The comparator result then serves all eight modes. The output is always the whole 64-bit source that was selected, even when only the low words were compared.

When the record input is set, the unit also gives a 4-bit condition field. The field comes from the comparison of the first operand against the second before any maximum swap, and the summary-overflow input is appended to it.

Top module: `minmax_unit`

## Requirements
- R1: With mode 3'b000 (unsigned, doubleword, minimum), res_o is the first source when it is unsigned-less than rb_i, and rb_i otherwise.
- R2: mode_i[1]=1 selects two's-complement ordering of the compared values. mode_i[1]=0 selects unsigned ordering.
- R3: mode_i[0]=1 compares only bits 31:0 of the operands. Bits 63:32 have no effect on which source is chosen.
- R4: In word mode, res_o carries all 64 bits of the chosen source, upper half included.
- R5: mode_i[2]=1 selects the maximum. The first source is chosen when it compares strictly greater than rb_i.
- R6: When the compared values are equal, res_o is rb_i in both minimum and maximum modes.
- R7: When ra_zero_i=1, the first source is the constant 0 for both the comparison and the output.
- R8: When rec_i=1, cr_valid_o=1 and cr_o={lt,gt,eq,so_i}. lt, gt and eq compare the first source against rb_i under the selected width and signedness, regardless of mode_i[2]. Exactly one of the three is set.
- R9: When rec_i=0, cr_valid_o=0 and cr_o=4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ra_i | input | 64 | First operand register value |
| rb_i | input | 64 | Second operand |
| ra_zero_i | input | 1 | Replace the first operand with zero |
| mode_i | input | 3 | Bit 0 word, bit 1 signed, bit 2 maximum |
| rec_i | input | 1 | Request the condition field |
| so_i | input | 1 | Summary-overflow bit appended to the field |
| res_o | output | 64 | Selected full source |
| cr_o | output | 4 | Condition field {lt,gt,eq,so} |
| cr_valid_o | output | 1 | Condition field is meaningful |

## Verification
The selection and the condition field come out in the same evaluation, and they read the comparator in opposite senses in maximum mode. The field keeps its pre-swap meaning while the selection flips. The bench applies every pair of boundary operands under all eight modes with the record bit toggling. On each clock a behavioural reference built from typed casts predicts both outputs. Operands whose upper halves differ while their low words match expose any leak of the upper bits into the word-mode decision, and any truncation of the returned value.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
  typedef struct packed {
    logic is_max;
    logic is_signed;
    logic is_word;
  } mm_mode_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_field_t;
endpackage

// File: rtl/mm_prep.sv
module mm_prep #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            word_i,
  input  logic            sgn_i,
  output logic [XLEN-1:0] key_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] placed;

  always_comb begin
    placed = word_i ? {val_i[HALF-1:0], {HALF{1'b0}}} : val_i;
    // flipped sign bit makes unsigned order match signed order
    key_o  = {placed[XLEN-1] ^ sgn_i, placed[XLEN-2:0]};
  end
endmodule

// File: rtl/mm_ucmp.sv
module mm_ucmp #(
  parameter int unsigned W     = 64,
  parameter int unsigned CHUNK = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         eq_o
);
  localparam int unsigned NCH = W / CHUNK;

  logic [NCH-1:0] c_lt;
  logic [NCH-1:0] c_eq;

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign c_lt[g] = a_i[g*CHUNK +: CHUNK] < b_i[g*CHUNK +: CHUNK];
    assign c_eq[g] = a_i[g*CHUNK +: CHUNK] == b_i[g*CHUNK +: CHUNK];
  end

  always_comb begin
    lt_o = 1'b0;
    eq_o = 1'b1;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eq_o) begin
        lt_o = c_lt[i];
        eq_o = c_eq[i];
      end
    end
  end
endmodule

// File: rtl/mm_cr.sv
module mm_cr
  import minmax_pkg::*;
(
  input  logic      lt_i,
  input  logic      eq_i,
  input  logic      rec_i,
  input  logic      so_i,
  output cr_field_t cr_o,
  output logic      valid_o
);
  always_comb begin
    cr_o    = '0;
    valid_o = rec_i;
    if (rec_i) begin
      cr_o.lt = lt_i;
      cr_o.eq = eq_i;
      cr_o.gt = ~lt_i & ~eq_i;
      cr_o.so = so_i;
    end
  end
endmodule

// File: rtl/minmax_unit.sv
module minmax_unit
  import minmax_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned CHUNK = 8
) (
  input  logic [XLEN-1:0] ra_i,
  input  logic [XLEN-1:0] rb_i,
  input  logic            ra_zero_i,
  input  logic [2:0]      mode_i,
  input  logic            rec_i,
  input  logic            so_i,
  output logic [XLEN-1:0] res_o,
  output logic [3:0]      cr_o,
  output logic            cr_valid_o
);
  mm_mode_t        mode;
  logic [XLEN-1:0] src_a;
  logic [XLEN-1:0] key_a;
  logic [XLEN-1:0] key_b;
  logic            a_lt_b;
  logic            a_eq_b;
  logic            take_a;
  cr_field_t       cr;

  assign mode  = mm_mode_t'(mode_i);
  assign src_a = ra_zero_i ? '0 : ra_i;

  mm_prep #(.XLEN(XLEN)) u_prep_a (
    .val_i(src_a), .word_i(mode.is_word), .sgn_i(mode.is_signed), .key_o(key_a)
  );
  mm_prep #(.XLEN(XLEN)) u_prep_b (
    .val_i(rb_i), .word_i(mode.is_word), .sgn_i(mode.is_signed), .key_o(key_b)
  );

  mm_ucmp #(.W(XLEN), .CHUNK(CHUNK)) u_cmp (
    .a_i(key_a), .b_i(key_b), .lt_o(a_lt_b), .eq_o(a_eq_b)
  );

  // max swaps operands: b < a is "greater and not equal"
  assign take_a = mode.is_max ? (~a_lt_b & ~a_eq_b) : a_lt_b;
  assign res_o  = take_a ? src_a : rb_i;

  mm_cr u_cr (
    .lt_i(a_lt_b), .eq_i(a_eq_b), .rec_i(rec_i), .so_i(so_i),
    .cr_o(cr), .valid_o(cr_valid_o)
  );
  assign cr_o = cr;
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic [XLEN-1:0] ra_i,
  input logic [XLEN-1:0] rb_i,
  input logic            ra_zero_i,
  input logic [2:0]      mode_i,
  input logic            rec_i,
  input logic            so_i,
  input logic [XLEN-1:0] res_o,
  input logic [3:0]      cr_o,
  input logic            cr_valid_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] a_src;
  logic            known;
  logic            same_key;

  always_comb begin
    a_src    = ra_zero_i ? '0 : ra_i;
    known    = !$isunknown({ra_i, rb_i, ra_zero_i, mode_i, rec_i, so_i, res_o, cr_o, cr_valid_o});
    same_key = mode_i[0] ? (a_src[HALF-1:0] == rb_i[HALF-1:0]) : (a_src == rb_i);
    if (known) begin
      assert_pick_source_R4: assert (res_o == a_src || res_o == rb_i);
      assert_tie_second_R6: assert (!same_key || res_o == rb_i);
      assert_zero_src_R7: assert (!ra_zero_i || res_o == '0 || res_o == rb_i);
      assert_cr_off_R9: assert (rec_i || (cr_o == 4'b0000 && !cr_valid_o));
      assert_cr_form_R8: assert (!rec_i || (cr_valid_o && $countones(cr_o[3:1]) == 1 && cr_o[0] == so_i));
      assert_cr_eq_R8: assert (!rec_i || (cr_o[1] == same_key));
      assert_unsigned_min_R1: assert (mode_i != 3'b000 || res_o != a_src || a_src == rb_i || a_src < rb_i);
      assert_signed_max_R5: assert (mode_i != 3'b110 || res_o != a_src || a_src == rb_i || $signed(a_src) > $signed(rb_i));
    end
  end
endmodule

bind minmax_unit mm_checker #(.XLEN(XLEN)) u_chk (
  .ra_i(ra_i), .rb_i(rb_i), .ra_zero_i(ra_zero_i), .mode_i(mode_i),
  .rec_i(rec_i), .so_i(so_i), .res_o(res_o), .cr_o(cr_o), .cr_valid_o(cr_valid_o)
);

// File: tb/sim_minmax_unit.sv
module sim_minmax_unit;
  logic        clk = 1'b0;
  logic [63:0] ra, rb, res;
  logic        ra_zero, rec, so, cr_valid;
  logic [2:0]  mode;
  logic [3:0]  cr;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  minmax_unit u0 (
    .ra_i(ra), .rb_i(rb), .ra_zero_i(ra_zero), .mode_i(mode),
    .rec_i(rec), .so_i(so), .res_o(res), .cr_o(cr), .cr_valid_o(cr_valid)
  );

  localparam logic [63:0] VALS [10] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 64'h1234_0000_0000_0005,
    64'hFEDC_0000_0000_0005, 64'h0000_0001_FFFF_FFFE, 64'hFFFF_FFFF_0000_0003
  };

  // reference ordering using typed casts: -1 less, 0 equal, 1 greater
  function automatic int ref_ord(logic [63:0] a, logic [63:0] b, logic [2:0] m);
    longint          sa = longint'(a), sb = longint'(b);
    longint unsigned ua = a, ub = b;
    int              wa = int'(a[31:0]), wb = int'(b[31:0]);
    int unsigned     va = a[31:0], vb = b[31:0];
    case (m[1:0])
      2'b00: return (ua < ub) ? -1 : (ua > ub) ? 1 : 0;
      2'b10: return (sa < sb) ? -1 : (sa > sb) ? 1 : 0;
      2'b01: return (va < vb) ? -1 : (va > vb) ? 1 : 0;
      default: return (wa < wb) ? -1 : (wa > wb) ? 1 : 0;
    endcase
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s res actual=%h expected=%h mode=%b", tag, act, exp, mode);
    end
  endtask

  task automatic check_cr(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cr actual=%b expected=%b mode=%b", tag, act, exp, mode);
    end
  endtask

  task automatic apply(logic [63:0] a, logic [63:0] b, logic z, logic [2:0] m, logic r, logic s);
    logic [63:0] asrc;
    int          o;
    logic        pick_a;
    logic [4:0]  exp_cr;
    string       tag;
    @(posedge clk);
    ra = a; rb = b; ra_zero = z; mode = m; rec = r; so = s;
    @(negedge clk);
    asrc   = z ? 64'h0 : a;
    o      = ref_ord(asrc, b, m);
    pick_a = m[2] ? (o > 0) : (o < 0);
    if (z) tag = "R7";
    else if (o == 0) tag = "R6";
    else if (m[0]) tag = "R3 R4";
    else if (m[2]) tag = "R5";
    else if (m[1]) tag = "R2";
    else tag = "R1";
    check64(tag, res, pick_a ? asrc : b);
    exp_cr = r ? {1'b1, o < 0, o > 0, o == 0, s} : 5'b0;
    check_cr(r ? "R8" : "R9", {cr_valid, cr}, exp_cr);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ra = '0; rb = '0; ra_zero = 1'b0; mode = 3'b000; rec = 1'b0; so = 1'b0;
    // idle state: no field requested (R9)
    @(negedge clk);
    check_cr("R9", {cr_valid, cr}, 5'b0);
    check64("R6", res, 64'h0);
    // upper halves differ, low words equal: word compare ties, rb returned whole (R3 R4 R6)
    apply(64'h1234_0000_0000_0005, 64'hFEDC_0000_0000_0005, 1'b0, 3'b001, 1'b1, 1'b1);
    // word min picks full first source with its upper half (R4)
    apply(64'hAAAA_BBBB_0000_0001, 64'h0000_0000_0000_0002, 1'b0, 3'b001, 1'b1, 1'b0);
    // signed max with negative operand; field keeps pre-swap sense (R5 R8)
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 3'b110, 1'b1, 1'b0);
    // register-zero source (R7)
    apply(64'h5, 64'h9, 1'b1, 3'b000, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        for (int m = 0; m < 8; m++) begin
          apply(VALS[i], VALS[j], 1'b0, 3'(m), 1'((i + m) % 2), 1'(j % 2));
        end
        apply(VALS[i], VALS[j], 1'b1, 3'(i % 8), 1'b1, 1'b0);
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule